// File: doc/BRIEF.md
# Virtual Channel Data Unit Builder

This block turns a byte stream of source packets into fixed-length data units of 1100 bytes. Each unit is an 8-byte header followed by a 1092-byte data field. Packets are placed back to back in the data field and may continue from one unit into the next. The finished bytes are written one per cycle into a byte-wide output FIFO of 4096 entries. A downstream framer drains that FIFO at a steady rate, and the FIFO reports its occupancy back to the block.

The data field of a unit is collected first in a local field buffer. The header is written afterwards, so it can state where the first packet of the unit begins. The block holds all reading and writing while the output FIFO is three-quarters full. When the FIFO runs low and the input has no packet waiting, the block inserts an idle packet so the framer is never starved. An idle packet is sized to end exactly on a unit boundary.

Top module: `vcdu_builder`

## Requirements
- R1: Units leave on `out_wr` back to back, each exactly 1100 bytes long: 8 header bytes, then 1092 data-field bytes. No byte is written while the block is collecting a data field.
- R2: Header bytes 0 and 1 are the marker 0x3A, 0x7E. Bytes 2 to 4 are a 24-bit unit count, most significant byte first; it is 0 for the first unit after reset, rises by one per unit and wraps modulo 2^24. Header byte 5 is 0x00.
- R3: While `out_level` is 3072 or more (3/4 of 4096), `out_wr` and `in_ready` are both low. At 3071 the block proceeds.
- R4: The data fields carry the accepted input bytes in their arrival order. A packet that does not fit continues at byte 0 of the next unit's data field.
- R5: Header bytes 6 and 7 form a 16-bit value, most significant byte first. It gives the offset within the data field of the first byte of the first packet that starts in that unit. A packet start is an input byte taken with `in_sop`, or the first byte of an idle packet. The value is 0x07FF when no packet starts in the unit.
- R6: An idle packet starts on the cycle after a clock edge at which all of these hold: the fill side is between packets, `in_valid` is low, `out_level` is below 1264, and the block is not held. While the idle packet is written, `in_ready` is low. Its bytes are 0x07, 0xFF, 0xC0, 0x00, then the 16-bit value (total length − 7) with the most significant byte first, then 0x55 fill. Its total length is the number of bytes left in the current data field if that is at least 7; otherwise it is that number plus 1092.
- R7: While `out_level` is 1264 or more, no idle packet starts. The block waits for input, with `in_ready` high while not held.
- R8: After reset `out_wr` is low, `in_ready` is high and the unit count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Block takes the input byte at this edge |
| in_data | input | 8 | Input packet byte |
| in_sop | input | 1 | Byte is the first of a packet |
| in_eop | input | 1 | Byte is the last of a packet |
| out_level | input | 13 | Current occupancy of the output FIFO |
| out_wr | output | 1 | Write strobe into the output FIFO |
| out_data | output | 8 | Byte written into the output FIFO |

## Verification
A wrong fill index or emit counter moves every following byte. This shows up at the next header marker, at the latest 1100 written bytes later, as a misplaced 0x3A/0x7E pair. A wrong first-packet offset register, or a unit count that is stale, is only visible in bytes 2 to 7 of the next header, one full field-collection time after the fault. A wrong idle-length or idle-position register shows at once in the idle header bytes. It also breaks the exact unit alignment at the end of the idle packet, so the following header and its offset of 0 reveal it. A throttle fault is visible in the same cycle as a write or an input acceptance while the level is at or above 3072.

// File: rtl/vcdu_pkg.sv
package vcdu_pkg;
  typedef enum logic {PH_FILL = 1'b0, PH_EMIT = 1'b1} phase_t;

  localparam int HDR_LEN  = 8;
  localparam int IDLE_MIN = 7;

  // Header byte at position idx of the 8-byte unit header.
  function automatic logic [7:0] hdr_byte(input logic [2:0] idx, input logic [15:0] mark,
                                          input logic [23:0] cnt, input logic [15:0] fhp);
    logic [7:0] b;
    case (idx)
      3'd0:    b = mark[15:8];
      3'd1:    b = mark[7:0];
      3'd2:    b = cnt[23:16];
      3'd3:    b = cnt[15:8];
      3'd4:    b = cnt[7:0];
      3'd5:    b = 8'h00;
      3'd6:    b = fhp[15:8];
      default: b = fhp[7:0];
    endcase
    return b;
  endfunction

  // Idle packet size: close the field exactly, or the field after it when too short.
  function automatic logic [15:0] idle_total(input logic [15:0] rem, input logic [15:0] dlen);
    return (rem >= 16'(IDLE_MIN)) ? rem : rem + dlen;
  endfunction

  // Byte at position pos of an idle packet of the given total size.
  function automatic logic [7:0] idle_byte(input logic [15:0] pos, input logic [15:0] total,
                                           input logic [7:0] fill);
    logic [15:0] len;
    logic [7:0]  b;
    len = total - 16'(IDLE_MIN);
    case (pos)
      16'd0:   b = 8'h07;
      16'd1:   b = 8'hFF;
      16'd2:   b = 8'hC0;
      16'd3:   b = 8'h00;
      16'd4:   b = len[15:8];
      16'd5:   b = len[7:0];
      default: b = fill;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/vcdu_field_buf.sv
module vcdu_field_buf #(
  parameter int DEPTH = 1092,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/vcdu_idle_gen.sv
module vcdu_idle_gen
  import vcdu_pkg::*;
#(
  parameter int         DATA_LEN = 1092,
  parameter logic [7:0] FILL     = 8'h55
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [15:0] rem,
  input  logic        advance,
  output logic        busy,
  output logic        first,
  output logic [7:0]  byte_o
);
  logic [15:0] left_q, pos_q, total_q, total_new;

  assign total_new = idle_total(rem, 16'(DATA_LEN));
  assign busy      = (left_q != 16'd0);
  assign first     = (pos_q == 16'd0);
  assign byte_o    = idle_byte(pos_q, total_q, FILL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q  <= '0;
      pos_q   <= '0;
      total_q <= '0;
    end else if (start) begin
      left_q  <= total_new;
      total_q <= total_new;
      pos_q   <= '0;
    end else if (advance && busy) begin
      left_q <= left_q - 16'd1;
      pos_q  <= pos_q + 16'd1;
    end
  end
endmodule

// File: rtl/vcdu_builder.sv
module vcdu_builder
  import vcdu_pkg::*;
#(
  parameter int          DATA_LEN    = 1092,
  parameter int          OFIFO_DEPTH = 4096,
  parameter int          LOW_MARK    = 1264,
  parameter logic [15:0] HDR_MARK    = 16'h3A7E,
  parameter logic [7:0]  IDLE_FILL   = 8'h55,
  localparam int         LW          = $clog2(OFIFO_DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_data,
  input  logic          in_sop,
  input  logic          in_eop,
  input  logic [LW-1:0] out_level,
  output logic          out_wr,
  output logic [7:0]    out_data
);
  localparam int THRESH   = (OFIFO_DEPTH * 3) / 4;
  localparam int AW       = $clog2(DATA_LEN);
  localparam int UNIT_LEN = HDR_LEN + DATA_LEN;
  localparam int EW       = $clog2(UNIT_LEN);
  localparam logic [AW-1:0] FHP_NONE = '1;

  phase_t        phase;
  logic [AW-1:0] fill_idx, fhp_q, fhp_now, rd_addr;
  logic [EW-1:0] emit_idx;
  logic [23:0]   unit_cnt;
  logic          in_pkt;

  // named internal events
  logic hold, take_in, idle_start, idle_adv, idle_busy, idle_first;
  logic fill_wr, pkt_start, field_full, unit_done;
  logic [7:0]  fill_byte, idle_b, buf_rd;
  logic [15:0] fill_rem;

  assign hold       = (out_level >= LW'(THRESH));
  assign in_ready   = (phase == PH_FILL) && !hold && !idle_busy;
  assign take_in    = in_valid && in_ready;
  assign idle_start = (phase == PH_FILL) && !hold && !in_pkt && !idle_busy && !in_valid
                      && (out_level < LW'(LOW_MARK));
  assign idle_adv   = (phase == PH_FILL) && !hold && idle_busy;
  assign fill_wr    = take_in || idle_adv;
  assign fill_byte  = idle_busy ? idle_b : in_data;
  assign pkt_start  = (take_in && in_sop) || (idle_adv && idle_first);
  assign fhp_now    = (fhp_q == FHP_NONE && pkt_start) ? fill_idx : fhp_q;
  assign field_full = fill_wr && (fill_idx == AW'(DATA_LEN - 1));
  assign fill_rem   = 16'(DATA_LEN) - 16'(fill_idx);

  assign out_wr    = (phase == PH_EMIT) && !hold;
  assign unit_done = out_wr && (emit_idx == EW'(UNIT_LEN - 1));
  assign rd_addr   = AW'(emit_idx - EW'(HDR_LEN));
  assign out_data  = (emit_idx < EW'(HDR_LEN))
                     ? hdr_byte(emit_idx[2:0], HDR_MARK, unit_cnt, 16'(fhp_q))
                     : buf_rd;

  vcdu_field_buf #(.DEPTH(DATA_LEN), .AW(AW)) buf_i (
    .clk(clk), .wr_en(fill_wr), .wr_addr(fill_idx), .wr_data(fill_byte),
    .rd_addr(rd_addr), .rd_data(buf_rd)
  );

  vcdu_idle_gen #(.DATA_LEN(DATA_LEN), .FILL(IDLE_FILL)) idle_i (
    .clk(clk), .rst_n(rst_n), .start(idle_start), .rem(fill_rem), .advance(idle_adv),
    .busy(idle_busy), .first(idle_first), .byte_o(idle_b)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_FILL;
      fill_idx <= '0;
      emit_idx <= '0;
      unit_cnt <= '0;
      fhp_q    <= FHP_NONE;
      in_pkt   <= 1'b0;
    end else begin
      if (take_in) in_pkt <= !in_eop;
      if (fill_wr) begin
        fhp_q    <= fhp_now;
        fill_idx <= field_full ? '0 : fill_idx + 1'b1;
        if (field_full) phase <= PH_EMIT;
      end
      if (out_wr) begin
        if (unit_done) begin
          emit_idx <= '0;
          phase    <= PH_FILL;
          unit_cnt <= unit_cnt + 24'd1;
          fhp_q    <= FHP_NONE;
        end else begin
          emit_idx <= emit_idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/vcdu_builder_chk.sv
module vcdu_builder_chk #(
  parameter int LW       = 13,
  parameter int AW       = 11,
  parameter int DATA_LEN = 1092,
  parameter int THRESH   = 3072,
  parameter int LOW_MARK = 1264
) (
  input logic          clk,
  input logic          rst_n,
  input logic [LW-1:0] out_level,
  input logic          out_wr,
  input logic          in_ready,
  input logic          unit_done,
  input logic [23:0]   unit_cnt,
  input logic          idle_busy,
  input logic [AW-1:0] fhp_q
);
  a_r3_hold_stops_both: assert property (@(posedge clk) disable iff (!rst_n)
    (out_level >= LW'(THRESH)) |-> (!out_wr && !in_ready));

  a_r1_no_write_while_filling: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_wr && in_ready));

  a_r2_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
    unit_done |=> (unit_cnt == $past(unit_cnt) + 24'd1));

  a_r6_idle_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    idle_busy |-> !in_ready);

  a_r5_offset_range: assert property (@(posedge clk) disable iff (!rst_n)
    (fhp_q == '1) || (fhp_q < AW'(DATA_LEN)));

  a_r7_idle_only_when_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle_busy) |-> ($past(out_level) < LW'(LOW_MARK)));
endmodule

bind vcdu_builder vcdu_builder_chk #(
  .LW(LW), .AW(AW), .DATA_LEN(DATA_LEN), .THRESH(THRESH), .LOW_MARK(LOW_MARK)
) chk_i (
  .clk(clk), .rst_n(rst_n), .out_level(out_level), .out_wr(out_wr), .in_ready(in_ready),
  .unit_done(unit_done), .unit_cnt(unit_cnt), .idle_busy(idle_busy), .fhp_q(fhp_q)
);

// File: tb/vcdu_builder_tb_top.sv
`timescale 1ns/1ps
module vcdu_builder_tb_top;
  localparam int DLEN  = 1092;
  localparam int ULEN  = 1100;
  localparam int NUNIT = 3;
  localparam int NS    = 2;
  // per scenario: four packet lengths (0 = none), then expected offset field of units 0..2
  localparam int VEC [NS][7] = '{
    '{300, 1500, 250, 40, 0, 708, 0},
    '{1000, 88, 0, 0, 0, 2047, 0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic [12:0] out_level = '0;
  logic        in_ready, out_wr;
  logic [7:0]  out_data;

  int n_chk = 0, n_fail = 0, ucount = 0;
  logic [7:0] got [0:NUNIT*ULEN-1];

  always #2 clk = ~clk;

  vcdu_builder dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sop(in_sop), .in_eop(in_eop), .out_level(out_level), .out_wr(out_wr), .out_data(out_data)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic int dbyte(int s, int g);
    return (g * 7 + s * 3 + 1) & 255;
  endfunction

  function automatic int exp_byte(int s, int k, int i, int p);
    int g, rem0, tot0, pos, tot;
    case (i)
      0: return 8'h3A;
      1: return 8'h7E;
      2, 3, 5: return 0;
      4: return k;
      6: return (VEC[s][4+k] >> 8) & 255;
      7: return VEC[s][4+k] & 255;
      default: ;
    endcase
    g = k * DLEN + i - 8;
    if (g < p) return dbyte(s, g);
    rem0 = DLEN - (p % DLEN);
    tot0 = (rem0 >= 7) ? rem0 : rem0 + DLEN;
    if (g < p + tot0) begin pos = g - p; tot = tot0; end
    else begin pos = (g - p - tot0) % DLEN; tot = DLEN; end
    case (pos)
      0: return 8'h07;
      1: return 8'hFF;
      2: return 8'hC0;
      3: return 8'h00;
      4: return ((tot - 7) >> 8) & 255;
      5: return (tot - 7) & 255;
      default: return 8'h55;
    endcase
  endfunction

  // output monitor, sampled between edges
  always @(negedge clk) begin
    #1;
    if (rst_n && out_wr) begin
      if (ucount < NUNIT * ULEN) got[ucount] = out_data;
      ucount++;
    end
    if (rst_n && out_level >= 13'd3072)
      chk(!out_wr && !in_ready, "R3 held at 3/4 full", {out_wr, in_ready}, 0);
  end

  task automatic do_reset();
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; out_level = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    ucount = 0;
  endtask

  task automatic run_scn(input int s);
    int g, p;
    bit first;
    string tag;
    do_reset();
    if (s == 0) fork
      begin
        repeat (600) @(negedge clk); out_level = 13'd3100;
        repeat (30)  @(negedge clk); out_level = '0;
        repeat (870) @(negedge clk); out_level = 13'd3100;
        repeat (20)  @(negedge clk); out_level = '0;
      end
    join_none
    g = 0; first = 1'b1;
    for (int n = 0; n < 4; n++) begin
      for (int b = 0; b < VEC[s][n]; b++) begin
        in_valid = 1'b1; in_data = 8'(dbyte(s, g));
        in_sop = (b == 0); in_eop = (b == VEC[s][n] - 1);
        if (first) begin
          rst_n = 1'b1; first = 1'b0;
          #0.5;
          if (s == 0) begin
            chk(out_wr == 1'b0, "R8 no write after reset", out_wr, 0);
            chk(in_ready == 1'b1, "R8 ready after reset", in_ready, 1);
          end
        end
        #0.5;
        while (!in_ready) begin @(negedge clk); #0.5; end
        @(negedge clk);
        g++;
      end
    end
    p = g;
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    while (ucount < NUNIT * ULEN) @(negedge clk);
    for (int k = 0; k < NUNIT; k++) begin
      for (int i = 0; i < ULEN; i++) begin
        if (i < 2)                  tag = "R1 unit marker";
        else if (i < 6)             tag = "R2 unit count";
        else if (i < 8)             tag = "R5 first packet offset";
        else if (k*DLEN+i-8 < p)    tag = "R4 packet data";
        else                        tag = "R6 idle packet";
        chk(got[k*ULEN+i] == 8'(exp_byte(s, k, i, p)), tag, got[k*ULEN+i], exp_byte(s, k, i, p));
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int s = 0; s < NS; s++) run_scn(s);

    // R7: level at the low-water mark, input absent: no idle fill starts
    do_reset();
    out_level = 13'd1264;
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
    #0.5 chk(out_wr == 1'b0, "R7 no output while waiting", out_wr, 0);
    in_valid = 1'b1; in_sop = 1'b1; in_eop = 1'b1; in_data = 8'h11;
    #0.5 chk(in_ready == 1'b1, "R7 input still accepted", in_ready, 1);
    @(negedge clk);
    // R6: one below the mark at a packet boundary: idle fill takes over
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; out_level = 13'd1263;
    repeat (3) @(negedge clk);
    #0.5 chk(in_ready == 1'b0, "R6 idle blocks input", in_ready, 0);

    // R3: throttle threshold edges
    do_reset();
    out_level = 13'd3072;
    in_valid = 1'b1; in_sop = 1'b1; in_eop = 1'b1; in_data = 8'h22;
    rst_n = 1'b1;
    #0.5 chk(in_ready == 1'b0, "R3 input held at 3072", in_ready, 0);
    repeat (5) @(negedge clk);
    #0.5 chk(in_ready == 1'b0, "R3 still held", in_ready, 0);
    out_level = 13'd3071;
    #0.5 chk(in_ready == 1'b1, "R3 resumes at 3071", in_ready, 1);
    @(negedge clk);
    in_valid = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule